// File: doc/BRIEF.md
# Signed-Count Multi-Mode Shifter

This block shifts an 8-bit word by an amount and in a direction that both come from one signed count. A positive count moves bits toward bit 0 (right) and a negative count moves them toward the top bit (left). A two-bit mode input selects between three shift modes and a pass-through code. The three shift modes are logical (zero fill), arithmetic (sign fill on right shifts, zero fill on left shifts) and rotate.

The shift itself is combinational. It is a logarithmic barrel network that only moves bits right. Left shifts reuse the same network by reversing the bit order of the word before it and after it. One output register stage, qualified by an input valid, lets the block sit in a pipelined datapath. Each result appears one cycle after the cycle in which it was presented.

Top module: `shf_signed_unit`

## Requirements
- R1: With mode 00 (logical) and a positive count n, the result is the input moved right by n places with zeros entering at the top; 10001101 with +3 gives 00010001.
- R2: With mode 00 and a negative count -n, the result is the input moved left by n places with zeros entering at bit 0; 10001101 with -2 gives 00110100.
- R3: With mode 01 (arithmetic) and a positive count, the vacated high bits take copies of input bit 7; 10001101 with +2 gives 11100011, and +7 gives all copies of bit 7.
- R4: With mode 01 and a negative count, the vacated low bits are zero, exactly as in mode 00; 10001101 with -3 gives 01101000.
- R5: With mode 10 (rotate), bits leaving one end enter the other; 10001101 with +1 gives 11000110 and with -2 gives 00110110. Rotation preserves the number of ones.
- R6: The count is a 4-bit two's-complement value from -8 to +7. Count 0 leaves the word unchanged in every mode. Count -8 (1000) gives zero in modes 00 and 01 and gives the unchanged word in mode 10, since a rotation uses the magnitude modulo 8.
- R7: Mode 11 passes the input word through unchanged for any count.
- R8: `out_valid` equals the value `in_valid` had one clock earlier. A result presented with `in_valid` high appears on `out_data` in the next cycle.
- R9: While `in_valid` is low, `out_data` keeps its last value whatever the other inputs do.
- R10: Reset is synchronous and active low. A clock edge with `rst_n` low clears `out_data` to 00000000 and `out_valid` to 0, even when `in_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands on this cycle are to be shifted and registered |
| in_data | input | 8 | Word to shift |
| in_count | input | 4 | Signed shift count, positive = right, negative = left |
| in_mode | input | 2 | 00 logical, 01 arithmetic, 10 rotate, 11 pass |
| out_valid | output | 1 | Registered result is valid |
| out_data | output | 8 | Registered shifted word |

## Verification
The case hardest to reach from the ports is the count -8. It is the only value whose magnitude fills the whole word, and it drives the top stage of the barrel network. In that stage, rotate has to do nothing, while logical and arithmetic-left must flush every bit. The stimulus sweeps all sixteen counts against all four modes for several words, including ones with the top bit set and clear. It then uses idle gaps with changing operands to expose any hold failure, and it pulls reset while a valid operand is present.

// File: rtl/shf_pkg.sv
// Package: shared mode encoding and sizing for the signed-count shifter.
// Assumes: the word width is a power of two.
package shf_pkg;

    typedef enum logic [1:0] {
        SHF_LOGIC = 2'b00,
        SHF_ARITH = 2'b01,
        SHF_ROT   = 2'b10,
        SHF_PASS  = 2'b11
    } shf_mode_e;

endpackage

// File: rtl/shf_count_decode.sv
// Module: splits a two's-complement count into a direction and a magnitude.
// Assumes: CNT_W = log2(WIDTH)+1, so the most negative count has magnitude WIDTH
// and the magnitude still fits in CNT_W bits.
module shf_count_decode #(
    parameter int CNT_W = 4
) (
    input  logic [CNT_W-1:0] count,
    output logic             go_left,
    output logic [CNT_W-1:0] magnitude
);

    // Purpose: the sign bit picks the direction; negate negative counts for the magnitude.
    always_comb begin
        go_left   = count[CNT_W-1];
        magnitude = go_left ? (~count + 1'b1) : count;
    end

endmodule

// File: rtl/shf_barrel_net.sv
// Module: right-only logarithmic barrel network; stage s moves the word by 2**s.
// Assumes: WIDTH is a power of two and STAGES = log2(WIDTH)+1. In the final stage
// (a move of WIDTH) a rotation is the identity and a fill shift flushes the word.
module shf_barrel_net #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 4
) (
    input  logic [WIDTH-1:0]  din,
    input  logic [STAGES-1:0] amount,
    input  logic              rotate,
    input  logic              fill,
    output logic [WIDTH-1:0]  dout
);

    logic [WIDTH-1:0] level [STAGES+1];

    assign level[0] = din;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        localparam int SH = 1 << s;
        logic [WIDTH-1:0] moved;
        if (SH < WIDTH) begin : g_part
            // Purpose: move right by SH, wrapping for rotate or inserting fill bits.
            always_comb begin
                moved = rotate ? {level[s][SH-1:0], level[s][WIDTH-1:SH]}
                               : {{SH{fill}}, level[s][WIDTH-1:SH]};
            end
        end else begin : g_full
            // Purpose: a full-width move is identity for rotate, all fill otherwise.
            always_comb begin
                moved = rotate ? level[s] : {WIDTH{fill}};
            end
        end
        assign level[s+1] = amount[s] ? moved : level[s];
    end

    assign dout = level[STAGES];

endmodule

// File: rtl/shf_signed_unit.sv
// Module: top of the signed-count shifter with one registered output stage.
// Assumes: CNT_W = log2(WIDTH)+1. Left shifts are done by reversing the word
// around the right-only network. Reset is synchronous, active low.
module shf_signed_unit
    import shf_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int LOG_W = $clog2(WIDTH),
    localparam int CNT_W = LOG_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_data,
    input  logic [CNT_W-1:0] in_count,
    input  logic [1:0]       in_mode,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_data
);

    logic             go_left;
    logic [CNT_W-1:0] magnitude;
    logic [WIDTH-1:0] net_in;
    logic [WIDTH-1:0] net_out;
    logic [WIDTH-1:0] shifted;
    logic [WIDTH-1:0] result;
    logic             fill_bit;
    logic             rot_sel;
    shf_mode_e        mode;

    assign mode = shf_mode_e'(in_mode);

    shf_count_decode #(.CNT_W(CNT_W)) u_dec (
        .count     (in_count),
        .go_left   (go_left),
        .magnitude (magnitude)
    );

    // Purpose: reverse the word for left moves so the network only shifts right.
    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            net_in[i] = go_left ? in_data[WIDTH-1-i] : in_data[i];
        end
    end

    // Purpose: sign fill only on arithmetic right moves; rotate select from mode.
    always_comb begin
        fill_bit = (mode == SHF_ARITH) && !go_left && in_data[WIDTH-1];
        rot_sel  = (mode == SHF_ROT);
    end

    shf_barrel_net #(.WIDTH(WIDTH), .STAGES(CNT_W)) u_net (
        .din    (net_in),
        .amount (magnitude),
        .rotate (rot_sel),
        .fill   (fill_bit),
        .dout   (net_out)
    );

    // Purpose: undo the reversal and apply the pass-through code.
    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            shifted[i] = go_left ? net_out[WIDTH-1-i] : net_out[i];
        end
        result = (mode == SHF_PASS) ? in_data : shifted;
    end

    // Purpose: output register, loaded only on valid input, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= result;
            end
        end
    end

    // R8: the valid flag tracks the input valid one cycle later.
    a_r8_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r8_valid_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R9: the data register holds while no valid input arrives.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));

    // R10: a reset edge clears both outputs.
    a_r10_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_data == '0));

    // R7: the pass code returns the word that was presented.
    a_r7_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 2'b11) |=> out_data == $past(in_data));

    // R5: rotation keeps the population count.
    a_r5_rot_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 2'b10) |=> $countones(out_data) == $countones($past(in_data)));

    // R6: the most negative count flushes a logical shift.
    a_r6_full_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 2'b00 && in_count == {1'b1, {LOG_W{1'b0}}}) |=> out_data == '0);

endmodule

// File: tb/shf_signed_unit_test.sv
module shf_signed_unit_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic [3:0] in_count = 4'h0;
    logic [1:0] in_mode = 2'b00;
    logic       out_valid;
    logic [7:0] out_data;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    typedef struct {
        logic [7:0] value;
        string      req;
    } exp_t;

    exp_t sb[$];

    always #5 clk = ~clk;

    shf_signed_unit uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_count  (in_count),
        .in_mode   (in_mode),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    // Bit-by-bit model of the requirements: result bit i comes from input bit i+c.
    function automatic logic [7:0] model(input logic [7:0] d, input logic [3:0] cnt,
                                         input logic [1:0] mode);
        int c;
        int src;
        logic [7:0] r;
        c = cnt[3] ? int'(cnt) - 16 : int'(cnt);
        for (int i = 0; i < 8; i++) begin
            src = i + c;
            case (mode)
                2'b00: r[i] = (src >= 0 && src < 8) ? d[src] : 1'b0;
                2'b01: r[i] = (src >= 0 && src < 8) ? d[src] : ((c > 0) ? d[7] : 1'b0);
                2'b10: r[i] = d[(src + 16) % 8];
                default: r[i] = d[i];
            endcase
        end
        return r;
    endfunction

    function automatic string req_of(input logic [3:0] cnt, input logic [1:0] mode);
        if (mode == 2'b11) return "R7";
        if (cnt == 4'd0 || cnt == 4'b1000) return "R6";
        if (mode == 2'b10) return "R5";
        if (mode == 2'b01) return cnt[3] ? "R4" : "R3";
        return cnt[3] ? "R2" : "R1";
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Driver: present one operand for one cycle and queue its expected result.
    task automatic drive(input logic [7:0] d, input logic [3:0] cnt, input logic [1:0] mode,
                         input string req);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        in_count = cnt;
        in_mode  = mode;
        e.value  = model(d, cnt, mode);
        e.req    = req;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: compare each valid result against the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && !done && out_valid) begin
            if (sb.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R8: actual out_valid 1 expected 0 (no result pending)");
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(e.req, out_data, e.value);
            end
        end
    end

    initial begin
        #2_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state.
        check("R10", {7'd0, out_valid}, 8'd0);
        check("R10", out_data, 8'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // Worked examples on 10001101.
        drive(8'h8D, 4'd3,        2'b00, "R1");
        drive(8'h8D, 4'hE,        2'b00, "R2");
        drive(8'h8D, 4'd2,        2'b01, "R3");
        drive(8'h8D, 4'hD,        2'b01, "R4");
        drive(8'h8D, 4'd1,        2'b10, "R5");
        drive(8'h8D, 4'hE,        2'b10, "R5");
        drive(8'h8D, 4'd7,        2'b01, "R3");
        drive(8'h7F, 4'd7,        2'b01, "R3");
        drive(8'h8D, 4'b1000,     2'b00, "R6");
        drive(8'h8D, 4'b1000,     2'b01, "R6");
        drive(8'h8D, 4'b1000,     2'b10, "R6");
        drive(8'h8D, 4'd5,        2'b11, "R7");
        idle(2);
        checks++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R8: actual %0d pending expected 0", sb.size());
        end

        // Full sweep of counts and modes over several words, back to back.
        foreach (sb[i]) begin end
        for (int w = 0; w < 5; w++) begin
            logic [7:0] word;
            case (w)
                0: word = 8'h8D;
                1: word = 8'h01;
                2: word = 8'h80;
                3: word = 8'h5A;
                default: word = 8'hF3;
            endcase
            for (int m = 0; m < 4; m++) begin
                for (int c = 0; c < 16; c++) begin
                    drive(word, 4'(c), 2'(m), req_of(4'(c), 2'(m)));
                end
            end
        end
        idle(2);

        // R9: operands change while valid is low; output must hold.
        drive(8'hC3, 4'd2, 2'b00, "R1");
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = 8'hFF;
        in_count = 4'hF;
        in_mode  = 2'b11;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            in_data = in_data - 8'd17;
            check("R9", out_data, 8'h30);
            check("R8", {7'd0, out_valid}, 8'd0);
        end

        // R10: reset wins over a valid operand.
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 8'hAA;
        in_mode  = 2'b11;
        rst_n    = 1'b0;
        @(negedge clk);
        check("R10", {7'd0, out_valid}, 8'd0);
        check("R10", out_data, 8'd0);
        in_valid = 1'b0;
        rst_n    = 1'b1;
        idle(1);
        drive(8'h8D, 4'hE, 2'b10, "R5");
        idle(2);

        done = 1;
        checks++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R8: actual %0d pending expected 0", sb.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule